// File: doc/BRIEF.md
# Loop-Disconnect Pulse Dialer

This block turns digit codes into timed interruptions of the telephone line loop. Each accepted digit becomes a train of break periods on an open-drain style dial line, with the break/make split chosen by a two-bit mode input and the rate chosen by a rate-select input. The same dial line also carries two other events: a timed flash break, which is followed by a recovery interval, and a hold that starts when the handset goes off-hook in lock mode. A pause code inserts a long idle wait. A mute output covers pulse trains and flashes, and a busy output tells the feeding logic when the next code may be sent.

All timing is counted in millisecond ticks taken from the system clock by a prescaler, so only the prescaler parameter changes with the clock frequency. While the hook input reports on-hook, the block is held idle. The tone generator, the keypad scan and digit storage are separate blocks. A code is accepted only while the block is idle.

Top module: `pulse_dialer`

## Requirements
- R1: Digit code N (1..9) produces exactly N break periods on `line_n_o` (0 = loop broken). Digit code 0 produces 10.
- R2: With `mode_i` = 2'b01 and `rate_sel_i` = 0, each break lasts 60 ms and each make between breaks lasts 40 ms.
- R3: With `mode_i` = 2'b10 and `rate_sel_i` = 0, each break lasts 67 ms and each make lasts 33 ms.
- R4: With `rate_sel_i` = 1, the break and make times are halved and rounded down: 30/20 ms for mode 2'b01 and 33/16 ms for mode 2'b10.
- R5: The last make of a train runs directly into an 800 ms inter-digit gap. During the gap `line_n_o` stays 1 and `busy_o` stays 1, and only then does `busy_o` fall. A strobe arriving during the gap is dropped.
- R6: `mute_n_o` is 0 from the first break of a train until the gap ends, and from the start of a flash until its recovery ends. It is 1 whenever the block is idle.
- R7: Code 4'hB makes a flash in any mode. The break lasts 73, 100, 300 or 600 ms for `flash_sel_i` = 00, 01, 10 or 11. It is followed by 1000 ms of recovery, with `line_n_o` at 1 and `mute_n_o` at 0.
- R8: Code 4'hA holds `busy_o` at 1 for 3600 ms, while `line_n_o` and `mute_n_o` stay at 1.
- R9: In tone mode (`mode_i` = 2'b00 or 2'b11), digit codes 0..9 leave all three outputs idle.
- R10: While `onhook_i` is 1, all outputs return to idle by the next clock edge, an activity in progress is abandoned, and strobes are dropped.
- R11: When `onhook_i` falls while `lock_en_i` is 1, `line_n_o` is held at 0 for 300 ms. During this hold `busy_o` is 1 and `mute_n_o` is 1.
- R12: Codes 4'hC to 4'hF are dropped. So are strobes that arrive while `busy_o` is 1.
- R13: After reset, `line_n_o` = 1, `mute_n_o` = 1 and `busy_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| onhook_i | input | 1 | 1 = handset on-hook (block held idle), 0 = off-hook |
| lock_en_i | input | 1 | Enables the 300 ms line hold on going off-hook |
| mode_i | input | 2 | 00/11 tone, 01 pulse 40:60, 10 pulse 33:67 |
| rate_sel_i | input | 1 | 0 = 10 pulses/s, 1 = 20 pulses/s |
| flash_sel_i | input | 2 | Flash break length select |
| code_i | input | 4 | 0..9 digit, A pause, B flash |
| code_vld_i | input | 1 | One-cycle strobe for `code_i` |
| line_n_o | output | 1 | Dial line, 0 = loop broken |
| mute_n_o | output | 1 | Speech mute, active low |
| busy_o | output | 1 | Activity in progress, codes not accepted |

## Verification
The pulse train is driven with a one-pulse digit, a mid-range digit and digit 0. Together these separate a wrong pulse count, an off-by-one in the last-pulse test, and the special case that maps 0 to ten pulses. Every break and make period is measured in clock cycles at each of the two ratios and both rates, which catches a swapped ratio, a missing halving and the rounding. Flash is tried with all four length selects and in both tone and pulse mode. Further runs check the pause, the lock hold, an on-hook abort in mid-train, strobes arriving in the gap, and codes that must be dropped, to show that each of these leaves no trace on the line.

// File: rtl/dial_pkg.sv
// Shared types and code points for the pulse dialer.
// Assumes: codes arrive as 4-bit values; mode is a 2-bit select.
package dial_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCK,
        ST_BREAK,
        ST_MAKE,
        ST_GAP,
        ST_FLASH,
        ST_RECOVER,
        ST_PAUSE
    } dial_state_e;

    typedef enum logic [1:0] {
        CK_NONE,
        CK_DIGIT,
        CK_PAUSE,
        CK_FLASH
    } code_kind_e;

    localparam logic [3:0] CODE_PAUSE = 4'hA;
    localparam logic [3:0] CODE_FLASH = 4'hB;

    localparam logic [1:0] MODE_P4060 = 2'b01;
    localparam logic [1:0] MODE_P3367 = 2'b10;

endpackage

// File: rtl/dial_decode.sv
// Combinational decode of the incoming code and the timing selects.
// Produces the kind of action, the pulse count, and the break, make
// and flash lengths in milliseconds.
// Assumes: digit codes count only in a pulse mode; flash and pause are
// accepted in every mode.
module dial_decode
    import dial_pkg::*;
#(
    parameter int TIME_W    = 12,
    parameter int BRK_A_MS  = 60,
    parameter int MK_A_MS   = 40,
    parameter int BRK_B_MS  = 67,
    parameter int MK_B_MS   = 33,
    parameter int FLASH0_MS = 73,
    parameter int FLASH1_MS = 100,
    parameter int FLASH2_MS = 300,
    parameter int FLASH3_MS = 600
) (
    input  logic [3:0]        code_i,
    input  logic [1:0]        mode_i,
    input  logic              rate_sel_i,
    input  logic [1:0]        flash_sel_i,
    output code_kind_e        kind_o,
    output logic [3:0]        count_o,
    output logic [TIME_W-1:0] brk_ms_o,
    output logic [TIME_W-1:0] mk_ms_o,
    output logic [TIME_W-1:0] flash_ms_o
);

    logic              pulse_mode;
    logic [TIME_W-1:0] brk_full;
    logic [TIME_W-1:0] mk_full;

    assign pulse_mode = (mode_i == MODE_P4060) || (mode_i == MODE_P3367);

    // Classify the code into an action kind.
    always_comb begin
        kind_o = CK_NONE;
        if (code_i <= 4'd9) begin
            kind_o = pulse_mode ? CK_DIGIT : CK_NONE;
        end else if (code_i == CODE_PAUSE) begin
            kind_o = CK_PAUSE;
        end else if (code_i == CODE_FLASH) begin
            kind_o = CK_FLASH;
        end
    end

    // Digit zero sends ten pulses.
    assign count_o = (code_i == 4'd0) ? 4'd10 : code_i;

    // Pick the break/make split from the mode select.
    always_comb begin
        if (mode_i == MODE_P3367) begin
            brk_full = TIME_W'(BRK_B_MS);
            mk_full  = TIME_W'(MK_B_MS);
        end else begin
            brk_full = TIME_W'(BRK_A_MS);
            mk_full  = TIME_W'(MK_A_MS);
        end
    end

    // The double rate halves both periods, rounding down.
    assign brk_ms_o = rate_sel_i ? (brk_full >> 1) : brk_full;
    assign mk_ms_o  = rate_sel_i ? (mk_full >> 1)  : mk_full;

    // Flash break length table.
    always_comb begin
        case (flash_sel_i)
            2'b00:   flash_ms_o = TIME_W'(FLASH0_MS);
            2'b01:   flash_ms_o = TIME_W'(FLASH1_MS);
            2'b10:   flash_ms_o = TIME_W'(FLASH2_MS);
            default: flash_ms_o = TIME_W'(FLASH3_MS);
        endcase
    end

endmodule

// File: rtl/dial_timer.sv
// Millisecond down-counter with its own clock prescaler.
// A load of V ms yields done_o in the last clock of V*TICK_DIV clocks,
// so the state that loaded it lasts exactly that many clocks.
// Assumes: the load value is never zero; a load beats a clear-free count.
module dial_timer #(
    parameter int TICK_DIV = 3580,
    parameter int TIME_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [TIME_W-1:0] load_ms_i,
    output logic              done_o
);

    logic [TIME_W-1:0] ms_left;
    logic              tick_wrap;

    generate
        if (TICK_DIV <= 1) begin : g_no_pre
            assign tick_wrap = 1'b1;
        end else begin : g_pre
            localparam int PRE_W = $clog2(TICK_DIV);
            logic [PRE_W-1:0] pre_cnt;

            assign tick_wrap = (pre_cnt == PRE_W'(TICK_DIV - 1));

            // Count clocks inside one millisecond, restarting on each load.
            always_ff @(posedge clk) begin
                if (!rst_n || clear_i || load_i) begin
                    pre_cnt <= '0;
                end else if (ms_left != '0) begin
                    pre_cnt <= tick_wrap ? '0 : pre_cnt + 1'b1;
                end
            end
        end
    endgenerate

    // Count the remaining milliseconds.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            ms_left <= '0;
        end else if (load_i) begin
            ms_left <= load_ms_i;
        end else if (ms_left != '0 && tick_wrap) begin
            ms_left <= ms_left - 1'b1;
        end
    end

    assign done_o = (ms_left == TIME_W'(1)) && tick_wrap;

    p_load_nonzero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (load_ms_i != '0));

    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clear_i) |=> (ms_left <= $past(ms_left)));

endmodule

// File: rtl/dial_seq.sv
// State machine of the dialer: accepts a code when idle, sequences
// the break/make pulses, gap, flash, recovery, pause and lock hold, and
// drives the timer.
// Assumes: on-hook has priority over everything; the lock hold starts on
// the clock after the hook input falls.
module dial_seq
    import dial_pkg::*;
#(
    parameter int TIME_W    = 12,
    parameter int GAP_MS    = 800,
    parameter int REC_MS    = 1000,
    parameter int PAUSE_MS  = 3600,
    parameter int LOCK_MS   = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              onhook_i,
    input  logic              lock_en_i,
    input  logic              code_vld_i,
    input  code_kind_e        kind_i,
    input  logic [3:0]        count_i,
    input  logic [TIME_W-1:0] brk_ms_i,
    input  logic [TIME_W-1:0] mk_ms_i,
    input  logic [TIME_W-1:0] flash_ms_i,
    input  logic              done_i,
    output logic              load_o,
    output logic [TIME_W-1:0] load_ms_o,
    output logic              clear_o,
    output dial_state_e       state_o
);

    dial_state_e       state;
    dial_state_e       nxt;
    logic              hook_q;
    logic [3:0]        pulses_left;
    logic [TIME_W-1:0] brk_q;
    logic [TIME_W-1:0] mk_q;
    logic              take_digit;

    // Next state and timer load selection.
    always_comb begin
        nxt       = state;
        load_o    = 1'b0;
        load_ms_o = '0;
        clear_o   = 1'b0;
        if (onhook_i) begin
            nxt     = ST_IDLE;
            clear_o = 1'b1;
        end else if (hook_q && lock_en_i) begin
            nxt       = ST_LOCK;
            load_o    = 1'b1;
            load_ms_o = TIME_W'(LOCK_MS);
        end else begin
            case (state)
                ST_IDLE: begin
                    if (code_vld_i) begin
                        case (kind_i)
                            CK_DIGIT: begin
                                nxt       = ST_BREAK;
                                load_o    = 1'b1;
                                load_ms_o = brk_ms_i;
                            end
                            CK_PAUSE: begin
                                nxt       = ST_PAUSE;
                                load_o    = 1'b1;
                                load_ms_o = TIME_W'(PAUSE_MS);
                            end
                            CK_FLASH: begin
                                nxt       = ST_FLASH;
                                load_o    = 1'b1;
                                load_ms_o = flash_ms_i;
                            end
                            default: nxt = ST_IDLE;
                        endcase
                    end
                end
                ST_BREAK: begin
                    if (done_i) begin
                        nxt       = ST_MAKE;
                        load_o    = 1'b1;
                        load_ms_o = mk_q;
                    end
                end
                ST_MAKE: begin
                    if (done_i) begin
                        load_o = 1'b1;
                        if (pulses_left == 4'd0) begin
                            nxt       = ST_GAP;
                            load_ms_o = TIME_W'(GAP_MS);
                        end else begin
                            nxt       = ST_BREAK;
                            load_ms_o = brk_q;
                        end
                    end
                end
                ST_FLASH: begin
                    if (done_i) begin
                        nxt       = ST_RECOVER;
                        load_o    = 1'b1;
                        load_ms_o = TIME_W'(REC_MS);
                    end
                end
                default: begin
                    if (done_i) begin
                        nxt = ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign take_digit = (state == ST_IDLE) && (nxt == ST_BREAK);

    // State and hook history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            hook_q <= 1'b1;
        end else begin
            state  <= nxt;
            hook_q <= onhook_i;
        end
    end

    // Pulse counter and latched timing of the current train.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulses_left <= '0;
            brk_q       <= '0;
            mk_q        <= '0;
        end else if (take_digit) begin
            pulses_left <= count_i - 4'd1;
            brk_q       <= brk_ms_i;
            mk_q        <= mk_ms_i;
        end else if (state == ST_MAKE && done_i && nxt == ST_BREAK) begin
            pulses_left <= pulses_left - 4'd1;
        end
    end

    assign state_o = state;

    p_onhook_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        onhook_i |=> (state == ST_IDLE));

    p_train_continues_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MAKE && done_i && pulses_left != 4'd0 && !onhook_i)
        |=> (state == ST_BREAK));

    p_gap_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MAKE && done_i && pulses_left == 4'd0 && !onhook_i)
        |=> (state == ST_GAP));

    p_gap_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP && !done_i && !onhook_i) |=> (state == ST_GAP));

    p_pulse_count_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pulses_left <= 4'd9));

endmodule

// File: rtl/pulse_dialer.sv
// Top of the loop-disconnect pulse dialer: decode, sequencer and
// millisecond timer, with outputs taken from the sequencer state.
// Assumes: TICK_DIV clocks make one millisecond.
module pulse_dialer
    import dial_pkg::*;
#(
    parameter int TICK_DIV  = 3580,
    parameter int TIME_W    = 12,
    parameter int BRK_A_MS  = 60,
    parameter int MK_A_MS   = 40,
    parameter int BRK_B_MS  = 67,
    parameter int MK_B_MS   = 33,
    parameter int FLASH0_MS = 73,
    parameter int FLASH1_MS = 100,
    parameter int FLASH2_MS = 300,
    parameter int FLASH3_MS = 600,
    parameter int GAP_MS    = 800,
    parameter int REC_MS    = 1000,
    parameter int PAUSE_MS  = 3600,
    parameter int LOCK_MS   = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       onhook_i,
    input  logic       lock_en_i,
    input  logic [1:0] mode_i,
    input  logic       rate_sel_i,
    input  logic [1:0] flash_sel_i,
    input  logic [3:0] code_i,
    input  logic       code_vld_i,
    output logic       line_n_o,
    output logic       mute_n_o,
    output logic       busy_o
);

    code_kind_e        kind;
    logic [3:0]        count;
    logic [TIME_W-1:0] brk_ms;
    logic [TIME_W-1:0] mk_ms;
    logic [TIME_W-1:0] flash_ms;
    logic              tmr_load;
    logic [TIME_W-1:0] tmr_load_ms;
    logic              tmr_clear;
    logic              tmr_done;
    dial_state_e       state;

    dial_decode #(
        .TIME_W   (TIME_W),
        .BRK_A_MS (BRK_A_MS),
        .MK_A_MS  (MK_A_MS),
        .BRK_B_MS (BRK_B_MS),
        .MK_B_MS  (MK_B_MS),
        .FLASH0_MS(FLASH0_MS),
        .FLASH1_MS(FLASH1_MS),
        .FLASH2_MS(FLASH2_MS),
        .FLASH3_MS(FLASH3_MS)
    ) u_decode (
        .code_i     (code_i),
        .mode_i     (mode_i),
        .rate_sel_i (rate_sel_i),
        .flash_sel_i(flash_sel_i),
        .kind_o     (kind),
        .count_o    (count),
        .brk_ms_o   (brk_ms),
        .mk_ms_o    (mk_ms),
        .flash_ms_o (flash_ms)
    );

    dial_seq #(
        .TIME_W  (TIME_W),
        .GAP_MS  (GAP_MS),
        .REC_MS  (REC_MS),
        .PAUSE_MS(PAUSE_MS),
        .LOCK_MS (LOCK_MS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .onhook_i  (onhook_i),
        .lock_en_i (lock_en_i),
        .code_vld_i(code_vld_i),
        .kind_i    (kind),
        .count_i   (count),
        .brk_ms_i  (brk_ms),
        .mk_ms_i   (mk_ms),
        .flash_ms_i(flash_ms),
        .done_i    (tmr_done),
        .load_o    (tmr_load),
        .load_ms_o (tmr_load_ms),
        .clear_o   (tmr_clear),
        .state_o   (state)
    );

    dial_timer #(
        .TICK_DIV(TICK_DIV),
        .TIME_W  (TIME_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (tmr_clear),
        .load_i   (tmr_load),
        .load_ms_i(tmr_load_ms),
        .done_o   (tmr_done)
    );

    // Output decode from the registered state.
    assign line_n_o = !(state == ST_BREAK || state == ST_FLASH || state == ST_LOCK);
    assign mute_n_o = !(state == ST_BREAK || state == ST_MAKE || state == ST_GAP ||
                        state == ST_FLASH || state == ST_RECOVER);
    assign busy_o   = (state != ST_IDLE);

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (line_n_o && mute_n_o));

    p_break_muted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_n_o && state != ST_LOCK) |-> !mute_n_o);

    p_onhook_outputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        onhook_i |=> (line_n_o && mute_n_o && !busy_o));

    p_lock_unmuted_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK) |-> (mute_n_o && !line_n_o));

endmodule

// File: tb/pulse_dialer_tb_top.sv
// Directed bench for the pulse dialer; durations measured in clocks.
module pulse_dialer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       onhook_i = 1'b0;
    logic       lock_en_i = 1'b0;
    logic [1:0] mode_i = 2'b01;
    logic       rate_sel_i = 1'b0;
    logic [1:0] flash_sel_i = 2'b00;
    logic [3:0] code_i = 4'd0;
    logic       code_vld_i = 1'b0;
    logic       line_n_o;
    logic       mute_n_o;
    logic       busy_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    pulse_dialer #(.TICK_DIV(DIV)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .onhook_i   (onhook_i),
        .lock_en_i  (lock_en_i),
        .mode_i     (mode_i),
        .rate_sel_i (rate_sel_i),
        .flash_sel_i(flash_sel_i),
        .code_i     (code_i),
        .code_vld_i (code_vld_i),
        .line_n_o   (line_n_o),
        .mute_n_o   (mute_n_o),
        .busy_o     (busy_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Send one code strobe; returns at the negedge after acceptance.
    task automatic strobe(input logic [3:0] c);
        @(negedge clk);
        code_i     = c;
        code_vld_i = 1'b1;
        @(negedge clk);
        code_vld_i = 1'b0;
    endtask

    // Count negedge samples while line equals lvl and busy is high.
    task automatic run_len(input logic lvl, output int n, output bit mhi, output bit mlo);
        n = 0; mhi = 1'b0; mlo = 1'b0;
        while (line_n_o == lvl && busy_o && n < 20000) begin
            if (mute_n_o) mhi = 1'b1; else mlo = 1'b1;
            n++;
            @(negedge clk);
        end
    endtask

    // Stay idle for a number of cycles.
    task automatic expect_idle(input int cyc, input string req);
        bit bad = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (busy_o || !line_n_o || !mute_n_o) bad = 1'b1;
        end
        check(!bad, req, int'(bad), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(line_n_o == 1'b1, "R13 line", int'(line_n_o), 1);
        check(mute_n_o == 1'b1, "R13 mute", int'(mute_n_o), 1);
        check(busy_o == 1'b0, "R13 busy", int'(busy_o), 0);
    endtask

    // One full pulse train with measured break/make/gap lengths.
    task automatic t_train(input logic [3:0] dig, input logic [1:0] md, input logic rt,
                           input int brk, input int mk, input string req);
        int nexp, n, good;
        bit mhi, mlo, mute_bad;
        nexp = (dig == 0) ? 10 : int'(dig);
        good = 0; mute_bad = 1'b0;
        mode_i = md; rate_sel_i = rt;
        strobe(dig);
        for (int i = 0; i < nexp; i++) begin
            run_len(1'b0, n, mhi, mlo);
            if (mhi) mute_bad = 1'b1;
            check(n == brk * DIV, {req, " break"}, n, brk * DIV);
            run_len(1'b1, n, mhi, mlo);
            if (mhi) mute_bad = 1'b1;
            if (i < nexp - 1) check(n == mk * DIV, {req, " make"}, n, mk * DIV);
            else check(n == (mk + 800) * DIV, "R5 make+gap", n, (mk + 800) * DIV);
            good++;
        end
        check(!busy_o && line_n_o, "R1 train ended", int'(busy_o), 0);
        check(!mute_bad, "R6 mute during train", int'(mute_bad), 0);
        check(mute_n_o, "R6 mute released", int'(mute_n_o), 1);
        expect_idle(20, "R1 no extra pulses");
    endtask

    // Strobe during the gap must be dropped.
    task automatic t_gap_strobe();
        int n, rest;
        bit mhi, mlo;
        mode_i = 2'b01; rate_sel_i = 1'b0;
        strobe(4'd1);
        run_len(1'b0, n, mhi, mlo);
        check(n == 60 * DIV, "R2 single break", n, 60 * DIV);
        for (int i = 0; i < (40 + 100) * DIV - 2; i++) @(negedge clk);
        strobe(4'd7);
        run_len(1'b1, rest, mhi, mlo);
        n = (40 + 100) * DIV + rest;
        check(n == (40 + 800) * DIV, "R12 gap length with strobe", n, (40 + 800) * DIV);
        expect_idle(400, "R12 strobe in gap dropped");
    endtask

    task automatic t_flash(input logic [1:0] sel, input logic [1:0] md, input int ms);
        int n;
        bit mhi, mlo, bad;
        mode_i = md; flash_sel_i = sel;
        strobe(4'hB);
        run_len(1'b0, n, mhi, mlo);
        bad = mhi;
        check(n == ms * DIV, "R7 flash break", n, ms * DIV);
        run_len(1'b1, n, mhi, mlo);
        bad = bad | mhi;
        check(n == 1000 * DIV, "R7 recovery", n, 1000 * DIV);
        check(!bad, "R6 mute during flash", int'(bad), 0);
        check(!busy_o, "R7 flash ended", int'(busy_o), 0);
    endtask

    task automatic t_pause();
        int n;
        bit mhi, mlo;
        mode_i = 2'b01;
        strobe(4'hA);
        run_len(1'b1, n, mhi, mlo);
        check(n == 3600 * DIV, "R8 pause length", n, 3600 * DIV);
        check(!mlo, "R8 mute stays high", int'(mlo), 0);
        check(line_n_o, "R8 line stays made", int'(line_n_o), 1);
    endtask

    task automatic t_tone();
        mode_i = 2'b00;
        strobe(4'd5);
        expect_idle(30, "R9 tone mode 00 digit");
        mode_i = 2'b11;
        strobe(4'd0);
        expect_idle(30, "R9 tone mode 11 digit");
    endtask

    task automatic t_invalid();
        mode_i = 2'b01;
        strobe(4'hC);
        expect_idle(20, "R12 code C dropped");
        strobe(4'hF);
        expect_idle(20, "R12 code F dropped");
    endtask

    task automatic t_onhook();
        mode_i = 2'b01; rate_sel_i = 1'b0;
        strobe(4'd9);
        for (int i = 0; i < 50; i++) @(negedge clk);
        check(busy_o, "R10 train running", int'(busy_o), 1);
        onhook_i = 1'b1;
        @(negedge clk);
        check(line_n_o && mute_n_o && !busy_o, "R10 abort to idle",
              int'({line_n_o, mute_n_o, busy_o}), 3'b110);
        strobe(4'd4);
        expect_idle(20, "R10 strobe on-hook dropped");
        onhook_i = 1'b0;
        expect_idle(20, "R10 off-hook without lock stays idle");
    endtask

    task automatic t_lock();
        int n;
        bit mhi, mlo;
        lock_en_i = 1'b1;
        @(negedge clk);
        onhook_i = 1'b1;
        for (int i = 0; i < 3; i++) @(negedge clk);
        onhook_i = 1'b0;
        @(negedge clk);
        run_len(1'b0, n, mhi, mlo);
        check(n == 300 * DIV, "R11 lock hold length", n, 300 * DIV);
        check(!mlo, "R11 mute high during hold", int'(mlo), 0);
        check(!busy_o && line_n_o, "R11 hold ended", int'(busy_o), 0);
        lock_en_i = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            report();
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_train(4'd3, 2'b01, 1'b0, 60, 40, "R2");
        t_train(4'd0, 2'b01, 1'b0, 60, 40, "R1 digit0");
        t_train(4'd2, 2'b10, 1'b0, 67, 33, "R3");
        t_train(4'd2, 2'b01, 1'b1, 30, 20, "R4 4060");
        t_train(4'd1, 2'b10, 1'b1, 33, 16, "R4 3367");
        t_gap_strobe();
        t_flash(2'b00, 2'b00, 73);
        t_flash(2'b01, 2'b01, 100);
        t_flash(2'b10, 2'b10, 300);
        t_flash(2'b11, 2'b01, 600);
        t_pause();
        t_tone();
        t_invalid();
        t_onhook();
        t_lock();
        done = 1'b1;
        report();
    end

endmodule